// File: doc/BRIEF.md
# PIRQ Interrupt Line Router

This block steers eight level-sensitive PCI interrupt request lines (PIRQ A to H) and one ACPI system control interrupt (SCI) onto a bank of 24 global interrupt lines. The low 16 lines feed a legacy cascaded controller and the upper 8 feed an advanced controller. Every PIRQ always reaches its own advanced-controller line. It can also reach one legacy pin, chosen by a per-PIRQ route byte. A legacy pin is the OR of every PIRQ steered to it.

Software programs eight route bytes and one SCI control byte through a byte-wide write port. The route bytes come in two groups of four. The SCI can be placed on legacy lines 9, 10 or 11, or on advanced lines 20 or 21. When the SCI moves to a different line, it is first removed from the old line and only then raised on the new one. The two lines are never both high, and the interrupt is not lost.

All outputs are registered, so the downstream controllers see glitch-free levels one clock after any change.

Top module: `pirq_router`

## Requirements
- R1: Route byte format: bits 3:0 give the legacy pin number, and bit 7 set disables legacy routing for that PIRQ. Bits 6:4 have no effect.
- R2: Legacy output pin p (0..15) is high when at least one PIRQ is high, has legacy routing enabled and has a pin number equal to p.
- R3: PIRQ n always drives global line 16+n, whatever its route byte says.
- R4: The SCI select code is bits 2:0 of the control byte. Codes 0, 1 and 2 place the SCI on lines 9, 10 and 11. Codes 4 and 5 place it on lines 20 and 21.
- R5: A write of a reserved SCI code (3, 6 or 7) leaves the SCI on the line it used before.
- R6: The SCI level is ORed into its selected line, on top of any PIRQ that also drives that line. It appears on no other line.
- R7: When a control write moves the SCI to a different line, the output for the cycle after the write edge carries the SCI on neither line. The following cycle carries it on the new line. Rewriting the current code causes no gap.
- R8: Reset sets all route bytes to 0x80 (legacy routing disabled, pin 0), sets the SCI line to 9 and clears all outputs.
- R9: Write addresses: 0 to 3 hold the routes for PIRQ A to D, 8 to 11 hold the routes for PIRQ E to H, and 12 holds the SCI control byte. Writes to any other address change nothing.
- R10: A change on pirq_in or sci_in appears on gsi_out after the next rising edge. A register write takes effect on gsi_out at the edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pirq_in | input | 8 | PIRQ A..H levels, bit 0 = A |
| sci_in | input | 1 | SCI level |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register byte address |
| cfg_wdata | input | 8 | Register write data |
| gsi_out | output | 24 | Global interrupt lines, 0..15 legacy, 16..23 advanced |

## Verification
The bench sweeps every PIRQ against every legacy pin number, and it checks the full 24-bit output vector each time. A wrong pin compare or a dropped disable bit therefore shows up as a stray or missing bit. Two PIRQs are made to share one pin, and the SCI is overlaid on a line that a PIRQ also drives. A design that replaced instead of ORing would lose one of the two sources in those cases. All eight SCI codes are written. Reserved codes are checked for retaining the previous line, since a design that cleared or defaulted the line would move the SCI silently. The move between lines is sampled cycle by cycle. This catches a design that shows the SCI on both lines at once, or that inserts a gap on a rewrite of the same code.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;

   localparam int unsigned SCI_LINE_W = 5;
   localparam logic [SCI_LINE_W-1:0] SCI_LINE_RESET = 5'd9;

   typedef struct packed {
      logic                  valid;
      logic [SCI_LINE_W-1:0] line;
   } sci_pick_t;

   // control byte bits 2:0 -> global line; codes 3,6,7 are reserved
   function automatic sci_pick_t decode_sci_code(input logic [2:0] code);
      sci_pick_t p;
      p.valid = 1'b1;
      case (code)
         3'd0:    p.line = 5'd9;
         3'd1:    p.line = 5'd10;
         3'd2:    p.line = 5'd11;
         3'd4:    p.line = 5'd20;
         3'd5:    p.line = 5'd21;
         default: begin
            p.valid = 1'b0;
            p.line  = '0;
         end
      endcase
      return p;
   endfunction

endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs #(
   parameter int unsigned NUM_PIRQ   = 8,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned IRQ_W      = 4,
   parameter int unsigned GRP_A_BASE = 0,
   parameter int unsigned GRP_B_BASE = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [ADDR_W-1:0]                 wr_addr,
   input  logic                              wr_dis,
   input  logic [IRQ_W-1:0]                  wr_irq,
   output logic [NUM_PIRQ-1:0]               route_dis,
   output logic [NUM_PIRQ-1:0][IRQ_W-1:0]    route_irq
);

   localparam int unsigned GRP_SIZE = 4;

   if (NUM_PIRQ > 2 * GRP_SIZE) begin : g_bad_count
      $error("pirq_route_regs: at most two groups of four PIRQs");
   end
   if (GRP_B_BASE < GRP_A_BASE + GRP_SIZE) begin : g_bad_base
      $error("pirq_route_regs: route groups overlap");
   end

   logic [NUM_PIRQ-1:0] slot_hit;

   for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_slot
      localparam int unsigned SLOT_INT =
         (n < GRP_SIZE) ? (GRP_A_BASE + n) : (GRP_B_BASE + n - GRP_SIZE);
      localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(SLOT_INT);

      assign slot_hit[n] = wr_en && (wr_addr == SLOT_ADDR);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            route_dis[n] <= 1'b1;
            route_irq[n] <= '0;
         end else if (slot_hit[n]) begin
            route_dis[n] <= wr_dis;
            route_irq[n] <= wr_irq;
         end
      end
   end

   // R9: a write that hits no route slot leaves every route untouched
   p_miss_keeps_routes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (slot_hit == '0)) |=> ($stable(route_dis) && $stable(route_irq)));

endmodule

// File: rtl/pirq_legacy_mux.sv
module pirq_legacy_mux #(
   parameter int unsigned NUM_PIRQ    = 8,
   parameter int unsigned LEGACY_PINS = 16,
   parameter int unsigned IRQ_W       = 4
) (
   input  logic [NUM_PIRQ-1:0]            pirq,
   input  logic [NUM_PIRQ-1:0]            route_dis,
   input  logic [NUM_PIRQ-1:0][IRQ_W-1:0] route_irq,
   output logic [LEGACY_PINS-1:0]         legacy
);

   if (LEGACY_PINS > (1 << IRQ_W)) begin : g_bad_width
      $error("pirq_legacy_mux: pin field too narrow for legacy pin count");
   end

   for (genvar p = 0; p < LEGACY_PINS; p++) begin : g_pin
      localparam logic [IRQ_W-1:0] PIN_ID = IRQ_W'(p);
      always_comb begin
         legacy[p] = 1'b0;
         for (int n = 0; n < NUM_PIRQ; n++) begin
            if (pirq[n] && !route_dis[n] && (route_irq[n] == PIN_ID))
               legacy[p] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/pirq_sci_steer.sv
module pirq_sci_steer
   import pirq_router_pkg::*;
#(
   parameter int unsigned GSI_LINES = 24,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned CTRL_ADDR = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [2:0]           wr_code,
   input  logic                 sci_in,
   output logic [GSI_LINES-1:0] sci_vec
);

   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

   if (GSI_LINES < 22) begin : g_bad_lines
      $error("pirq_sci_steer: SCI targets need at least 22 lines");
   end

   sci_pick_t             pick;
   logic                  ctrl_wr;
   logic                  move;
   logic [SCI_LINE_W-1:0] line_q;
   logic                  gap_q;

   assign pick    = decode_sci_code(wr_code);
   assign ctrl_wr = wr_en && (wr_addr == CTRL_A);
   assign move    = ctrl_wr && pick.valid && (pick.line != line_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= SCI_LINE_RESET;
         gap_q  <= 1'b0;
      end else begin
         gap_q <= move;
         if (move) line_q <= pick.line;
      end
   end

   always_comb begin
      sci_vec = '0;
      if (sci_in && !gap_q) sci_vec[line_q] = 1'b1;
   end

   // R5: reserved codes never move the SCI
   p_reserved_keeps_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !pick.valid) |=> $stable(line_q));

   // R7: break before make when the line changes
   p_gap_on_move_r7: assert property (@(posedge clk) disable iff (!rst_n)
      move |=> (sci_vec == '0));

   // R6: SCI sits on at most one line
   p_single_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sci_vec));

endmodule

// File: rtl/pirq_router.sv
module pirq_router #(
   parameter int unsigned NUM_PIRQ    = 8,
   parameter int unsigned LEGACY_PINS = 16,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned GRP_A_BASE  = 0,
   parameter int unsigned GRP_B_BASE  = 8,
   parameter int unsigned CTRL_ADDR   = 12
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_PIRQ-1:0]             pirq_in,
   input  logic                            sci_in,
   input  logic                            cfg_wr,
   input  logic [ADDR_W-1:0]               cfg_addr,
   input  logic [7:0]                      cfg_wdata,
   output logic [LEGACY_PINS+NUM_PIRQ-1:0] gsi_out
);

   localparam int unsigned GSI_LINES = LEGACY_PINS + NUM_PIRQ;
   localparam int unsigned IRQ_W     = $clog2(LEGACY_PINS);
   localparam int unsigned DIS_BIT   = 7;

   if (IRQ_W > DIS_BIT) begin : g_bad_field
      $error("pirq_router: pin field collides with disable bit");
   end

   logic [NUM_PIRQ-1:0]            route_dis;
   logic [NUM_PIRQ-1:0][IRQ_W-1:0] route_irq;
   logic [LEGACY_PINS-1:0]         legacy;
   logic [GSI_LINES-1:0]           sci_vec;
   logic [GSI_LINES-1:0]           gsi_next;
   logic                           live_q;
   logic                           unused_wdata;

   assign unused_wdata = ^cfg_wdata[DIS_BIT-1:IRQ_W];

   pirq_route_regs #(
      .NUM_PIRQ  (NUM_PIRQ),
      .ADDR_W    (ADDR_W),
      .IRQ_W     (IRQ_W),
      .GRP_A_BASE(GRP_A_BASE),
      .GRP_B_BASE(GRP_B_BASE)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_wr),
      .wr_addr  (cfg_addr),
      .wr_dis   (cfg_wdata[DIS_BIT]),
      .wr_irq   (cfg_wdata[IRQ_W-1:0]),
      .route_dis(route_dis),
      .route_irq(route_irq)
   );

   pirq_legacy_mux #(
      .NUM_PIRQ   (NUM_PIRQ),
      .LEGACY_PINS(LEGACY_PINS),
      .IRQ_W      (IRQ_W)
   ) u_mux (
      .pirq     (pirq_in),
      .route_dis(route_dis),
      .route_irq(route_irq),
      .legacy   (legacy)
   );

   pirq_sci_steer #(
      .GSI_LINES(GSI_LINES),
      .ADDR_W   (ADDR_W),
      .CTRL_ADDR(CTRL_ADDR)
   ) u_sci (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_wr),
      .wr_addr(cfg_addr),
      .wr_code(cfg_wdata[2:0]),
      .sci_in (sci_in),
      .sci_vec(sci_vec)
   );

   assign gsi_next = {pirq_in, legacy} | sci_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gsi_out <= '0;
         live_q  <= 1'b0;
      end else begin
         gsi_out <= gsi_next;
         live_q  <= 1'b1;
      end
   end

   // R3: each PIRQ reaches its fixed advanced line one clock later
   for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_chk
      p_fixed_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (live_q && $past(pirq_in[n])) |-> gsi_out[LEGACY_PINS+n]);
   end

endmodule

// File: tb/sim_pirq_router.sv
module sim_pirq_router;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  pirq_in = '0;
   logic        sci_in = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic [23:0] gsi_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic       m_dis [8];
   logic [3:0] m_irq [8];
   int         m_line;

   always #2 clk = ~clk;

   pirq_router u0 (
      .clk(clk), .rst_n(rst_n), .pirq_in(pirq_in), .sci_in(sci_in),
      .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .gsi_out(gsi_out)
   );

   task automatic check(input string tag, input logic [23:0] got, input logic [23:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %06h expected %06h", tag, got, exp);
      end
   endtask

   function automatic logic [23:0] model(input logic [7:0] p, input logic s);
      logic [23:0] r = '0;
      for (int n = 0; n < 8; n++) begin
         r[16+n] = p[n];
         if (p[n] && !m_dis[n]) r[m_irq[n]] = 1'b1;
      end
      if (s) r[m_line] = 1'b1;
      return r;
   endfunction

   function automatic int code_line(input int code);
      if (code < 3) return 9 + code;
      if (code == 4 || code == 5) return 16 + code;
      return -1;
   endfunction

   task automatic model_reset();
      for (int n = 0; n < 8; n++) begin
         m_dis[n] = 1'b1;
         m_irq[n] = '0;
      end
      m_line = 9;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic wr_route(input int n, input logic [7:0] d);
      wr((n < 4) ? 4'(n) : 4'(n + 4), d);
      m_dis[n] = d[7];
      m_irq[n] = d[3:0];
   endtask

   task automatic apply(input string tag, input logic [7:0] p, input logic s);
      @(negedge clk);
      pirq_in = p; sci_in = s;
      @(negedge clk);
      check(tag, gsi_out, model(p, s));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 outputs clear after reset", gsi_out, '0);
      apply("R8 default routes disabled", 8'hFF, 1'b0);
      apply("R8 default SCI line 9", 8'h00, 1'b1);

      // R3: each PIRQ alone on its fixed line
      for (int n = 0; n < 8; n++) apply("R3 fixed advanced line", 8'(1 << n), 1'b0);

      // R2: every PIRQ against every legacy pin
      for (int n = 0; n < 8; n++) begin
         for (int p = 0; p < 16; p++) begin
            wr_route(n, 8'(p));
            apply("R2 pin sweep", 8'(1 << n), 1'b0);
         end
      end
      wr_route(0, 8'h07);
      wr_route(4, 8'h07);
      apply("R2 shared pin A only", 8'h01, 1'b0);
      apply("R2 shared pin E only", 8'h10, 1'b0);
      apply("R2 shared pin both", 8'h11, 1'b0);
      apply("R2 shared pin none", 8'h00, 1'b0);

      // R1: disable bit and ignored middle bits
      wr_route(2, 8'h8B);
      apply("R1 disabled route", 8'h04, 1'b0);
      check("R1 pin 11 silent", {23'd0, gsi_out[11]}, 24'd0);
      wr_route(2, 8'h75);
      apply("R1 bits 6:4 ignored", 8'h04, 1'b0);
      check("R1 pin 5 driven", {23'd0, gsi_out[5]}, 24'd1);

      // R9: stray addresses change nothing
      wr(4'd4, 8'h03);
      wr(4'd7, 8'h01);
      wr(4'd13, 8'h02);
      wr(4'd15, 8'h05);
      apply("R9 stray writes ignored", 8'hFF, 1'b1);

      // R4 / R5: SCI code sweep with SCI held high
      for (int c = 0; c < 8; c++) begin
         if (code_line(c) >= 0) begin
            wr(4'd12, 8'(c));
            m_line = code_line(c);
            apply("R4 SCI code select", 8'h00, 1'b1);
         end
      end
      wr(4'd12, 8'h01);
      m_line = 10;
      for (int c = 3; c < 8; c++) begin
         if (code_line(c) < 0) begin
            wr(4'd12, 8'(c));
            apply("R5 reserved code keeps line", 8'h00, 1'b1);
         end
      end
      wr(4'd12, 8'hF9);
      apply("R4 upper control bits ignored", 8'h00, 1'b1);

      // R6: SCI and PIRQ on the same line
      wr_route(1, 8'h0A);
      apply("R6 PIRQ only on SCI pin", 8'h02, 1'b0);
      apply("R6 SCI plus PIRQ", 8'h02, 1'b1);
      apply("R6 SCI only", 8'h00, 1'b1);
      wr(4'd12, 8'h04);
      m_line = 20;
      apply("R6 SCI over advanced line", 8'h10, 1'b1);
      apply("R6 SCI alone advanced line", 8'h00, 1'b1);

      // R7: break before make
      wr(4'd12, 8'h00);
      m_line = 9;
      apply("R7 setup", 8'h00, 1'b1);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = 4'd12; cfg_wdata = 8'h05;
      @(negedge clk);
      cfg_wr = 1'b0;
      check("R7 old line before gap", gsi_out, 24'(1 << 9));
      @(negedge clk);
      check("R7 gap cycle", gsi_out, 24'd0);
      @(negedge clk);
      check("R7 new line", gsi_out, 24'(1 << 21));
      m_line = 21;
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = 4'd12; cfg_wdata = 8'h05;
      @(negedge clk);
      cfg_wr = 1'b0;
      @(negedge clk);
      check("R7 same code no gap", gsi_out, 24'(1 << 21));

      // R10: latency
      @(negedge clk);
      pirq_in = 8'h80; sci_in = 1'b0;
      #1 check("R10 before edge", gsi_out, 24'(1 << 21));
      @(negedge clk);
      check("R10 after one edge", gsi_out, model(8'h80, 1'b0));
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = 4'd3; cfg_wdata = 8'h0E;
      @(negedge clk);
      cfg_wr = 1'b0;
      check("R10 write not yet visible", gsi_out, model(8'h80, 1'b0));
      m_dis[3] = 1'b0; m_irq[3] = 4'hE;
      pirq_in = 8'h08;
      @(negedge clk);
      check("R10 write visible", gsi_out, model(8'h08, 1'b0));

      // R8: reset after configuration
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R8 outputs clear in reset", gsi_out, '0);
      rst_n = 1'b1;
      model_reset();
      apply("R8 routes back to default", 8'hFF, 1'b1);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule